// File: doc/BRIEF.md
# Flash Access Wait-State Controller

This block stands between a processor-side request port and a single-ported flash array model. It serves reads, single-word programs and page erases. Each request address is sorted into one of four cases: the 64-page main array, a 1 KB window that reaches the top page by a second address, a read-only boot region, or no region at all. Reads complete after a programmable number of extra cycles. Programs and erases are first checked against a per-page lock vector.

Software picks the extra-cycle count from the core clock. Use 0 at or below 24 MHz, 1 up to 48 MHz, 2 up to 72 MHz and 3 up to 96 MHz. Before the clock is raised, the count must be raised. When the clock is lowered, the count is lowered only after the clock has come down. The controller latches the count when it accepts an access, so rewriting the count while an access is in progress never changes that access. Only one access is outstanding at a time. The requester keeps its request steady until the response strobe appears.

Top module: `flash_wait_gate`

## Requirements
- R1: While reset is active and right after it, `respReady`, `arrRead`, `arrWrite` and `arrErase` are 0 and `cfgWaitOut` reads 0.
- R2: An address below 0x0001_0000 selects main page addr[15:10] and word addr[9:2]. A read from it returns that word of storage, which is presented on `arrAddr` as {1'b0, page, word}.
- R3: Addresses 0x1FF0_0000 to 0x1FF0_03FF reach the same storage as 0x0000_FC00 to 0x0000_FFFF (page 63, word addr[9:2]). A write through either address is visible through the other.
- R4: Addresses 0x1F00_0000 to 0x1F00_0FFF are a boot region. A read returns word addr[11:2] of it, presented as `arrAddr` bit 14 set. A program or erase aimed at it is refused with an error.
- R5: A read with a valid address raises `respReady` exactly WAIT+1 cycles after the clock edge that accepts it. A request is accepted on an edge where the controller is idle and `reqValid` is 1.
- R6: A write of `cfgWaitIn` through `cfgWrite` stores the value, but any value above 3 is stored as 3. `cfgWaitOut` shows the stored value from the next cycle on.
- R7: Writing a new wait count while a read is waiting leaves that read's latency unchanged. The next accepted read uses the new count.
- R8: Program (op 1) or erase (op 2) to main page n, where n is 0 to 62, is refused when `pageProtect[n]` is 1. Page 63, by either address, is refused only when `optProtect` is 1. A refusal answers one cycle after acceptance with `respError`=1, whatever the wait count, and the array is left unchanged.
- R9: An address in no region, or op code 3, answers one cycle after acceptance with `respError`=1. `respRdata` is zero on every response except a successful read.
- R10: A permitted erase sets all 256 words of the addressed page (`arrAddr[13:8]`) to all-ones. Other pages are left untouched. It answers one cycle after acceptance.
- R11: A permitted program (op 1) writes `reqWdata` to the addressed word and answers one cycle after acceptance. Op 0 is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; held until respReady |
| reqOp | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Program data |
| respReady | output | 1 | Response strobe, one cycle |
| respError | output | 1 | Response is a refusal or decode miss |
| respRdata | output | 32 | Read data, zero unless a successful read |
| cfgWrite | input | 1 | Load the wait count |
| cfgWaitIn | input | 3 | New wait count |
| cfgWaitOut | output | 3 | Stored wait count |
| pageProtect | input | 63 | Lock bit per main page 0 to 62 |
| optProtect | input | 1 | Lock bit for page 63 |
| arrRead | output | 1 | Array read strobe |
| arrWrite | output | 1 | Array single-word write strobe |
| arrErase | output | 1 | Array page erase strobe |
| arrAddr | output | 15 | {boot select, page, word} |
| arrWdata | output | 32 | Array write data |
| arrRdata | input | 32 | Array read data |

## Verification
The hardest case to reach is a wait-count write that arrives in the middle of a read. The stimulus sets the count to 3 and starts a read. A second branch runs in parallel and writes 0 two cycles later, while the read is still counting. The scoreboard expects a latency of 4 for that read and 1 for the next one. The alias window is tested by writing through one address of page 63 and reading back through the other, both with its lock bit cleared and with it set, while every other page lock is held at 1.

// File: rtl/flash_wait_pkg.sv
package flash_wait_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } flashOp_t;

  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_MAIN,
    RGN_ALIAS,
    RGN_BOOT
  } region_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic tick;
    logic finRead;
    logic finProg;
    logic finErase;
    logic finFail;
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_wait_dp.sv
module flash_wait_dp
  import flash_wait_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int DATA_W          = 32,
  parameter int WAIT_W          = 3,
  parameter int WAIT_MAX        = 3,
  parameter int PAGE_WORDS_LOG2 = 8,
  parameter int PAGE_CNT_LOG2   = 6,
  parameter int BOOT_WORDS_LOG2 = 10,
  parameter logic [ADDR_W-1:0] MAIN_BASE  = '0,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h1FF0_0000,
  parameter logic [ADDR_W-1:0] BOOT_BASE  = 32'h1F00_0000
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  ctrlStrobe_t                           strobe,
  input  logic [ADDR_W-1:0]                     reqAddr,
  input  logic [DATA_W-1:0]                     reqWdata,
  input  logic                                  cfgWrite,
  input  logic [WAIT_W-1:0]                     cfgWaitIn,
  input  logic [(1<<PAGE_CNT_LOG2)-2:0]         pageProtect,
  input  logic                                  optProtect,
  input  logic [DATA_W-1:0]                     arrRdata,
  output region_t                               decRegion,
  output logic                                  decLocked,
  output logic                                  cntZero,
  output logic [WAIT_W-1:0]                     cfgWaitOut,
  output logic                                  respReady,
  output logic                                  respError,
  output logic [DATA_W-1:0]                     respRdata,
  output logic                                  arrRead,
  output logic                                  arrWrite,
  output logic                                  arrErase,
  output logic [PAGE_CNT_LOG2+PAGE_WORDS_LOG2:0] arrAddr,
  output logic [DATA_W-1:0]                     arrWdata
);

  localparam int BYTE_OFS  = $clog2(DATA_W / 8);
  localparam int PAGE_SPAN = PAGE_WORDS_LOG2 + BYTE_OFS;
  localparam int MAIN_SPAN = PAGE_SPAN + PAGE_CNT_LOG2;
  localparam int BOOT_SPAN = BOOT_WORDS_LOG2 + BYTE_OFS;
  localparam int IDX_W     = PAGE_CNT_LOG2 + PAGE_WORDS_LOG2;
  localparam int LAST_PAGE = (1 << PAGE_CNT_LOG2) - 1;

  // ---------------- address decode ----------------
  logic                       inMain, inAlias, inBoot;
  logic [PAGE_CNT_LOG2-1:0]   pageNum;
  logic [PAGE_WORDS_LOG2-1:0] slotNum;
  logic [BOOT_WORDS_LOG2-1:0] bootSlot;
  logic [LAST_PAGE:0]         protAll;
  logic [IDX_W:0]             decArrAddr;
  logic                       unusedLsb;

  always_comb begin
    inMain    = (reqAddr >> MAIN_SPAN) == (MAIN_BASE >> MAIN_SPAN);
    inAlias   = (reqAddr >> PAGE_SPAN) == (ALIAS_BASE >> PAGE_SPAN);
    inBoot    = (reqAddr >> BOOT_SPAN) == (BOOT_BASE >> BOOT_SPAN);
    pageNum   = inAlias ? PAGE_CNT_LOG2'(LAST_PAGE) : reqAddr[MAIN_SPAN-1:PAGE_SPAN];
    slotNum   = reqAddr[PAGE_SPAN-1:BYTE_OFS];
    bootSlot  = reqAddr[BOOT_SPAN-1:BYTE_OFS];
    unusedLsb = ^reqAddr[BYTE_OFS-1:0];
    // top page is guarded by its own bit, placed above the per-page vector
    protAll   = {optProtect, pageProtect};
    decLocked = protAll[pageNum];
    if (inBoot) begin
      decRegion  = RGN_BOOT;
      decArrAddr = {1'b1, IDX_W'(bootSlot)};
    end else begin
      decRegion  = inAlias ? RGN_ALIAS : (inMain ? RGN_MAIN : RGN_NONE);
      decArrAddr = {1'b0, pageNum, slotNum};
    end
  end

  // ---------------- wait count register ----------------
  logic [WAIT_W-1:0] waitReg, waitNext;

  generate
    if (WAIT_MAX >= (1 << WAIT_W) - 1) begin : g_noSat
      assign waitNext = cfgWaitIn;
    end else begin : g_sat
      assign waitNext = (cfgWaitIn > WAIT_W'(WAIT_MAX)) ? WAIT_W'(WAIT_MAX) : cfgWaitIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         waitReg <= '0;
    else if (cfgWrite) waitReg <= waitNext;
  end

  assign cfgWaitOut = waitReg;

  // ---------------- per-access state ----------------
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitCap;
  logic              lockCap;
  logic [IDX_W:0]    arrAddrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt  <= '0;
      waitCap  <= '0;
      lockCap  <= 1'b0;
      arrAddrQ <= '0;
      wdataQ   <= '0;
    end else if (strobe.capture) begin
      waitCnt  <= waitReg;
      waitCap  <= waitReg;
      lockCap  <= decLocked;
      arrAddrQ <= decArrAddr;
      wdataQ   <= reqWdata;
    end else if (strobe.tick) begin
      waitCnt  <= waitCnt - WAIT_W'(1);
    end
  end

  assign cntZero   = (waitCnt == '0);
  assign arrRead   = strobe.finRead;
  assign arrWrite  = strobe.finProg;
  assign arrErase  = strobe.finErase;
  assign arrAddr   = arrAddrQ;
  assign arrWdata  = wdataQ;
  assign respReady = strobe.finRead | strobe.finProg | strobe.finErase | strobe.finFail;
  assign respError = strobe.finFail;
  assign respRdata = strobe.finRead ? arrRdata : '0;

  // ---------------- checking ----------------
  logic [WAIT_W:0] sinceCap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        sinceCap <= '0;
    else if (strobe.capture)          sinceCap <= (WAIT_W+1)'(1);
    else if (respReady)               sinceCap <= '0;
    else if (sinceCap != '0 && sinceCap != '1) sinceCap <= sinceCap + (WAIT_W+1)'(1);
  end

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finRead |-> sinceCap == ({1'b0, waitCap} + (WAIT_W+1)'(1)))
    else $error("read finished off its latched wait count");

  assert_boot_untouched_R4: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrite || arrErase) |-> !arrAddr[IDX_W])
    else $error("array modify aimed at boot region");

  assert_lock_honoured_R8: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrite || arrErase) |-> !lockCap)
    else $error("array modify on a locked page");

  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.finRead, strobe.finProg, strobe.finErase, strobe.finFail}))
    else $error("more than one response kind at once");

endmodule

// File: rtl/flash_wait_fsm.sv
module flash_wait_fsm
  import flash_wait_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  flashOp_t    reqOp,
  input  region_t     decRegion,
  input  logic        decLocked,
  input  logic        cntZero,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_WAIT,
    ST_PROG,
    ST_ERASE,
    ST_FAIL
  } state_t;

  state_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (decRegion == RGN_NONE || reqOp == OP_RSVD) stateNext = ST_FAIL;
          else if (reqOp == OP_READ)                      stateNext = ST_READ_WAIT;
          else if (decRegion == RGN_BOOT || decLocked)    stateNext = ST_FAIL;
          else if (reqOp == OP_PROG)                      stateNext = ST_PROG;
          else                                            stateNext = ST_ERASE;
        end
      end
      ST_READ_WAIT: if (cntZero) stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe          = '0;
    strobe.capture  = (state == ST_IDLE) && reqValid;
    strobe.tick     = (state == ST_READ_WAIT) && !cntZero;
    strobe.finRead  = (state == ST_READ_WAIT) && cntZero;
    strobe.finProg  = (state == ST_PROG);
    strobe.finErase = (state == ST_ERASE);
    strobe.finFail  = (state == ST_FAIL);
  end

  assert_back_to_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finRead || strobe.finProg || strobe.finErase || strobe.finFail) |=> state == ST_IDLE)
    else $error("controller did not return to idle after a response");

endmodule

// File: rtl/flash_wait_gate.sv
module flash_wait_gate
  import flash_wait_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int DATA_W          = 32,
  parameter int WAIT_W          = 3,
  parameter int WAIT_MAX        = 3,
  parameter int PAGE_WORDS_LOG2 = 8,
  parameter int PAGE_CNT_LOG2   = 6,
  parameter int BOOT_WORDS_LOG2 = 10
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  input  logic [1:0]                            reqOp,
  input  logic [ADDR_W-1:0]                     reqAddr,
  input  logic [DATA_W-1:0]                     reqWdata,
  output logic                                  respReady,
  output logic                                  respError,
  output logic [DATA_W-1:0]                     respRdata,
  input  logic                                  cfgWrite,
  input  logic [WAIT_W-1:0]                     cfgWaitIn,
  output logic [WAIT_W-1:0]                     cfgWaitOut,
  input  logic [(1<<PAGE_CNT_LOG2)-2:0]         pageProtect,
  input  logic                                  optProtect,
  output logic                                  arrRead,
  output logic                                  arrWrite,
  output logic                                  arrErase,
  output logic [PAGE_CNT_LOG2+PAGE_WORDS_LOG2:0] arrAddr,
  output logic [DATA_W-1:0]                     arrWdata,
  input  logic [DATA_W-1:0]                     arrRdata
);

  ctrlStrobe_t strobe;
  region_t     decRegion;
  logic        decLocked;
  logic        cntZero;

  flash_wait_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (flashOp_t'(reqOp)),
    .decRegion (decRegion),
    .decLocked (decLocked),
    .cntZero   (cntZero),
    .strobe    (strobe)
  );

  flash_wait_dp #(
    .ADDR_W          (ADDR_W),
    .DATA_W          (DATA_W),
    .WAIT_W          (WAIT_W),
    .WAIT_MAX        (WAIT_MAX),
    .PAGE_WORDS_LOG2 (PAGE_WORDS_LOG2),
    .PAGE_CNT_LOG2   (PAGE_CNT_LOG2),
    .BOOT_WORDS_LOG2 (BOOT_WORDS_LOG2)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .cfgWrite    (cfgWrite),
    .cfgWaitIn   (cfgWaitIn),
    .pageProtect (pageProtect),
    .optProtect  (optProtect),
    .arrRdata    (arrRdata),
    .decRegion   (decRegion),
    .decLocked   (decLocked),
    .cntZero     (cntZero),
    .cfgWaitOut  (cfgWaitOut),
    .respReady   (respReady),
    .respError   (respError),
    .respRdata   (respRdata),
    .arrRead     (arrRead),
    .arrWrite    (arrWrite),
    .arrErase    (arrErase),
    .arrAddr     (arrAddr),
    .arrWdata    (arrWdata)
  );

endmodule

// File: tb/test_flash_wait_gate.sv
module test_flash_wait_gate;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqOp;
  logic [31:0] reqAddr;
  logic [31:0] reqWdata;
  logic        respReady;
  logic        respError;
  logic [31:0] respRdata;
  logic        cfgWrite;
  logic [2:0]  cfgWaitIn;
  logic [2:0]  cfgWaitOut;
  logic [62:0] pageProtect;
  logic        optProtect;
  logic        arrRead, arrWrite, arrErase;
  logic [14:0] arrAddr;
  logic [31:0] arrWdata;
  logic [31:0] arrRdata;

  always #2 clk = ~clk;

  flash_wait_gate i_flash_wait_gate (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .respReady(respReady), .respError(respError), .respRdata(respRdata),
    .cfgWrite(cfgWrite), .cfgWaitIn(cfgWaitIn), .cfgWaitOut(cfgWaitOut),
    .pageProtect(pageProtect), .optProtect(optProtect), .arrRead(arrRead),
    .arrWrite(arrWrite), .arrErase(arrErase), .arrAddr(arrAddr), .arrWdata(arrWdata),
    .arrRdata(arrRdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural array ----------------
  function automatic logic [31:0] mainInit(input int idx);
    logic [31:0] v;
    v = 32'(idx);
    return 32'hC0DE_0000 ^ {v[15:0], ~v[15:0]};
  endfunction

  function automatic logic [31:0] bootInit(input int idx);
    return 32'hB007_0000 | 32'(idx);
  endfunction

  logic [31:0] mainMem [int];
  int memVer = 0;

  always @(arrAddr or memVer) begin
    if (arrAddr[14])                          arrRdata = bootInit(int'(arrAddr[9:0]));
    else if (mainMem.exists(int'(arrAddr[13:0]))) arrRdata = mainMem[int'(arrAddr[13:0])];
    else                                      arrRdata = mainInit(int'(arrAddr[13:0]));
  end

  always @(posedge clk) begin
    if (arrWrite) begin
      mainMem[int'(arrAddr[13:0])] = arrWdata;
      memVer++;
    end
    if (arrErase) begin
      for (int i = 0; i < 256; i++) mainMem[int'({arrAddr[13:8], 8'(i)})] = '1;
      memVer++;
    end
  end

  // ---------------- reference contents ----------------
  logic [31:0] refMem [int];

  function automatic logic [31:0] refWord(input int idx);
    return refMem.exists(idx) ? refMem[idx] : mainInit(idx);
  endfunction

  // ---------------- scoreboard ----------------
  typedef struct {
    int          lat;
    logic        err;
    logic [31:0] data;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  task automatic issue(input logic [1:0] op, input logic [31:0] addr, input logic [31:0] wdata,
                       input logic expErr, input logic [31:0] expData, input int expLat,
                       input string tag);
    expItem_t it;
    @(negedge clk);
    reqValid = 1'b1;
    reqOp    = op;
    reqAddr  = addr;
    reqWdata = wdata;
    it.lat = expLat; it.err = expErr; it.data = expData; it.tag = tag;
    expQ.push_back(it);
    do @(negedge clk); while (!respReady);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic setWait(input logic [2:0] v);
    @(negedge clk);
    cfgWrite  = 1'b1;
    cfgWaitIn = v;
    @(negedge clk);
    cfgWrite  = 1'b0;
  endtask

  // monitor: samples 1 ns after each rising edge
  bit inFlight = 0;
  bit justDone = 0;
  int lat = 0;

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (justDone) begin
          if (!reqValid) justDone = 0;
        end else if (!inFlight && reqValid) begin
          inFlight = 1;
          lat = 0;
        end
        if (inFlight) begin
          lat++;
          if (respReady) begin
            expItem_t it;
            if (expQ.size() == 0) begin
              chk(1'b0, "scoreboard empty", 32'(lat), 32'd0);
            end else begin
              it = expQ.pop_front();
              chk(lat == it.lat, {it.tag, " latency"}, 32'(lat), 32'(it.lat));
              chk(respError == it.err, {it.tag, " error"}, 32'(respError), 32'(it.err));
              chk(respRdata == it.data, {it.tag, " rdata"}, respRdata, it.data);
            end
            inFlight = 0;
            justDone = 1;
          end else if (lat > 20) begin
            chk(1'b0, "response timeout", 32'(lat), 32'd0);
            inFlight = 0;
          end
        end else if (respReady && !justDone) begin
          chk(1'b0, "spurious response", 32'd1, 32'd0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  localparam logic [1:0] OPR = 2'd0, OPP = 2'd1, OPE = 2'd2, OPX = 2'd3;

  task automatic rd(input logic [31:0] addr, input int idx, input int latExp, input string tag);
    issue(OPR, addr, 32'd0, 1'b0, refWord(idx), latExp, tag);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqAddr = '0; reqWdata = '0;
    cfgWrite = 1'b0; cfgWaitIn = '0; pageProtect = '0; optProtect = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(respReady == 1'b0, "R1 respReady in reset", 32'(respReady), 32'd0);
    chk({arrRead, arrWrite, arrErase} == 3'b000, "R1 strobes in reset", 32'({arrRead, arrWrite, arrErase}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(cfgWaitOut == 3'd0, "R1 wait after reset", 32'(cfgWaitOut), 32'd0);
    chk(respReady == 1'b0, "R1 respReady after reset", 32'(respReady), 32'd0);

    // R2 main array decode, R5 zero-wait latency
    rd(32'h0000_0000, 0, 1, "R2 R5 page0 word0");
    rd(32'h0000_2804, 32'h0A01, 1, "R2 page10 word1");
    rd(32'h0000_FFFC, 32'h3FFF, 1, "R2 last main word");

    // R6 saturation, R5 latency follows the count
    setWait(3'd2);
    chk(cfgWaitOut == 3'd2, "R6 wait 2", 32'(cfgWaitOut), 32'd2);
    rd(32'h0000_0100, 32'h40, 3, "R5 wait2 read");
    setWait(3'd7);
    chk(cfgWaitOut == 3'd3, "R6 wait 7 saturates", 32'(cfgWaitOut), 32'd3);
    rd(32'h0000_0104, 32'h41, 4, "R5 wait3 read");
    setWait(3'd5);
    chk(cfgWaitOut == 3'd3, "R6 wait 5 saturates", 32'(cfgWaitOut), 32'd3);

    // R7 change during an access
    fork
      rd(32'h0000_0108, 32'h42, 4, "R7 read keeps latched wait");
      begin
        @(negedge clk);
        @(negedge clk);
        setWait(3'd0);
      end
    join
    chk(cfgWaitOut == 3'd0, "R7 new wait stored", 32'(cfgWaitOut), 32'd0);
    rd(32'h0000_010C, 32'h43, 1, "R7 next read uses new wait");

    // R11 program
    issue(OPP, 32'h0000_0408, 32'h1234_5678, 1'b0, 32'd0, 1, "R11 program");
    refMem[32'h102] = 32'h1234_5678;
    rd(32'h0000_0408, 32'h102, 1, "R11 readback");

    // R8 per-page lock
    pageProtect[5] = 1'b1;
    issue(OPP, 32'h0000_1400, 32'hDEAD_BEEF, 1'b1, 32'd0, 1, "R8 program locked page5");
    rd(32'h0000_1400, 32'h500, 1, "R8 page5 unchanged");
    issue(OPE, 32'h0000_1404, 32'd0, 1'b1, 32'd0, 1, "R8 erase locked page5");
    rd(32'h0000_17FC, 32'h5FF, 1, "R8 page5 end unchanged");
    issue(OPP, 32'h0000_13FC, 32'h4444_0004, 1'b0, 32'd0, 1, "R8 page4 open");
    refMem[32'h4FF] = 32'h4444_0004;
    rd(32'h0000_13FC, 32'h4FF, 1, "R8 page4 readback");
    setWait(3'd2);
    issue(OPP, 32'h0000_1408, 32'h1, 1'b1, 32'd0, 1, "R8 refusal single cycle at wait2");
    setWait(3'd0);

    // R10 erase
    issue(OPP, 32'h0000_0800, 32'hAAAA_5555, 1'b0, 32'd0, 1, "R11 program page2");
    refMem[32'h200] = 32'hAAAA_5555;
    issue(OPE, 32'h0000_0A00, 32'd0, 1'b0, 32'd0, 1, "R10 erase page2");
    for (int i = 0; i < 256; i++) refMem[32'h200 + i] = '1;
    rd(32'h0000_0800, 32'h200, 1, "R10 page2 first word");
    rd(32'h0000_0BFC, 32'h2FF, 1, "R10 page2 last word");
    rd(32'h0000_0C00, 32'h300, 1, "R10 page3 untouched");
    rd(32'h0000_07FC, 32'h1FF, 1, "R10 page1 untouched");

    // R3 alias window and page-63 lock
    pageProtect = '1;
    optProtect  = 1'b0;
    issue(OPP, 32'h1FF0_0010, 32'h0BAD_F00D, 1'b0, 32'd0, 1, "R3 program via alias");
    refMem[32'h3F04] = 32'h0BAD_F00D;
    rd(32'h0000_FC10, 32'h3F04, 1, "R3 read physical");
    issue(OPP, 32'h0000_FFF0, 32'h7777_0001, 1'b0, 32'd0, 1, "R8 page63 ignores page bits");
    refMem[32'h3FFC] = 32'h7777_0001;
    rd(32'h1FF0_03F0, 32'h3FFC, 1, "R3 read alias");
    optProtect = 1'b1;
    issue(OPP, 32'h0000_FC20, 32'h1, 1'b1, 32'd0, 1, "R8 page63 locked physical");
    issue(OPE, 32'h1FF0_0000, 32'd0, 1'b1, 32'd0, 1, "R8 page63 locked alias");
    rd(32'h1FF0_0010, 32'h3F04, 1, "R8 page63 unchanged");
    rd(32'h0000_FC20, 32'h3F08, 1, "R8 page63 word8 unchanged");

    // R4 boot region
    pageProtect = '0;
    optProtect  = 1'b0;
    issue(OPR, 32'h1F00_0008, 32'd0, 1'b0, bootInit(2), 1, "R4 boot read");
    issue(OPR, 32'h1F00_0FFC, 32'd0, 1'b0, bootInit(1023), 1, "R4 boot last word");
    issue(OPP, 32'h1F00_0010, 32'h5, 1'b1, 32'd0, 1, "R4 boot program refused");
    issue(OPE, 32'h1F00_0000, 32'd0, 1'b1, 32'd0, 1, "R4 boot erase refused");
    issue(OPR, 32'h1F00_0010, 32'd0, 1'b0, bootInit(4), 1, "R4 boot unchanged");

    // R9 decode misses and reserved op
    setWait(3'd3);
    issue(OPR, 32'h2000_0000, 32'd0, 1'b1, 32'd0, 1, "R9 unmapped");
    issue(OPR, 32'h0001_0000, 32'd0, 1'b1, 32'd0, 1, "R9 above main");
    issue(OPR, 32'h1F00_1000, 32'd0, 1'b1, 32'd0, 1, "R9 above boot");
    issue(OPR, 32'h1FF0_0400, 32'd0, 1'b1, 32'd0, 1, "R9 above alias");
    issue(OPP, 32'h3000_0000, 32'h9, 1'b1, 32'd0, 1, "R9 program unmapped");
    issue(OPX, 32'h0000_0000, 32'd0, 1'b1, 32'd0, 1, "R9 reserved op");
    rd(32'h0000_0000, 0, 4, "R9 array intact");

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, "scoreboard drained", 32'(expQ.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule